// File: doc/BRIEF.md
# Programmable Interrupt Router with Edge Capture

This block collects `N_SRC` raw interrupt lines (32 by default) and turns them into two request outputs for a processor, plus a wake output. Each line passes through a two-flop synchroniser. A 3-bit trigger code chooses how the line is judged: not at all, rising edge, falling edge, either edge, high level or low level. Edges are captured in sticky status registers, one register for each direction. Software acknowledges a captured edge by writing a 1 to its bit.

A line counts as pending when its trigger condition holds and its enable (mask) bit is set. An assignment bit sends each pending line to the urgent request `req_hi_o` or to the ordinary request `req_lo_o`. A wake-enable register chooses which trigger conditions drive `wake_o`, and the mask has no effect on that output.

Software reaches the block through a plain single-cycle register port: a write strobe, a byte address and write data, with combinational read data. Nothing streams through the block, so the port has no valid/ready handshake and never stalls: every write is taken on the clock edge where `bus_wr_en` is high.

Top module: `irq_router_ctl`

## Requirements
- R1: Each of the trigger-code-0, trigger-code-1, trigger-code-2, spare, assignment, wake-enable and mask registers has a set address and a clear address. The set addresses are 0x40, 0x48, 0x50, 0x58, 0x60, 0x68 and 0x70, and each clear address is its set address plus 4. A 1 written at the set address sets that bit, a 1 written at the clear address clears it, and 0 bits change nothing. A read at the set address returns the register.
- R2: After reset the trigger codes, assignment, wake-enable, mask, both edge status registers and the test register are all zero, the spare register (0x58) is all ones, and all three outputs are low.
- R3: The trigger code of line i is {code2[i], code1[i], code0[i]}: 001 rising edge, 010 falling edge, 011 either edge, 101 high level, 110 low level. Any other code (000, 100, 111) never makes the line pending.
- R4: A rising edge detected on a line whose code selects rising edges sets its bit at 0x78, and a falling edge detected on a line whose code selects falling edges sets its bit at 0x7C. The bit stays set until a write of 1 to that bit at the same address. A write of 0 leaves it set.
- R5: If an edge is detected in the same cycle as the write that clears its status bit, the bit ends up set.
- R6: A line with mask bit 0 never drives `req_hi_o` or `req_lo_o`, and never shows in the pending readouts.
- R7: Pending lines with assignment bit 1 drive `req_hi_o` and read back at 0x54. Pending lines with assignment bit 0 drive `req_lo_o` and read back at 0x5C.
- R8: The request outputs are registered: an output changes one clock after the pending readout changes.
- R9: `wake_o` is the registered OR over all lines of (trigger condition AND wake-enable bit), whatever the mask holds.
- R10: Unmapped offsets and the clear-only offsets 0x44, 0x4C, 0x64, 0x6C and 0x74 read as 0. Writes to unmapped offsets change no state.
- R11: Offset 0x80 holds a 32-bit test register that reads back what was last written.
- R12: A level change on a raw input shows in the pending readout after the second rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe; the write is taken on this clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_raw | input | 32 | Asynchronous interrupt inputs, one per line |
| req_hi_o | output | 1 | Urgent processor request (assignment bit 1) |
| req_lo_o | output | 1 | Ordinary processor request (assignment bit 0) |
| wake_o | output | 1 | Wake indication, ignores the mask |

## Verification
Edge capture and software acknowledgement can meet in one cycle: a detected edge sets a status bit while a write-one-to-clear aimed at that same bit lands on the same clock edge. The bench provokes this by raising a line and timing the clear write so that it lands on the third rising edge after the input change, which is when the synchroniser reports the edge. It then reads 0x78 and requires the bit to be set. The remaining rules (mask gating, routing, wake without the mask, decoding of unused codes) are judged from the request outputs and the readback registers after the synchroniser has settled.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CODE0_SET = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CODE0_CLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_CODE1_SET = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_CODE1_CLR = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_CODE2_SET = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_CODE2_CLR = 8'h54; // read: urgent pending
  localparam logic [ADDR_W-1:0] OFS_SPARE_SET = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_SPARE_CLR = 8'h5C; // read: ordinary pending
  localparam logic [ADDR_W-1:0] OFS_ROUTE_SET = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_CLR = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_WAKE_SET  = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_WAKE_CLR  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_ENA_SET   = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_ENA_CLR   = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_RISE_STAT = 8'h78;
  localparam logic [ADDR_W-1:0] OFS_FALL_STAT = 8'h7C;
  localparam logic [ADDR_W-1:0] OFS_TEST      = 8'h80;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;
endpackage

// File: rtl/irq_src_front.sv
module irq_src_front #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw_i,
  output logic [N_SRC-1:0] lvl_o,
  output logic [N_SRC-1:0] rise_o,
  output logic [N_SRC-1:0] fall_o
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], raw_i[i]};
    end
    assign lvl_o[i]  = chain_q[CHAIN-2];
    assign rise_o[i] = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    assign fall_o[i] = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
  end
endmodule

// File: rtl/irq_eval.sv
module irq_eval
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] code0_i,
  input  logic [N_SRC-1:0] code1_i,
  input  logic [N_SRC-1:0] code2_i,
  input  logic [N_SRC-1:0] ena_i,
  input  logic [N_SRC-1:0] route_i,
  input  logic [N_SRC-1:0] wake_en_i,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] fall_i,
  input  logic [N_SRC-1:0] rise_stat_i,
  input  logic [N_SRC-1:0] fall_stat_i,
  output logic [N_SRC-1:0] rise_set_o,
  output logic [N_SRC-1:0] fall_set_o,
  output logic [N_SRC-1:0] pend_hi_o,
  output logic [N_SRC-1:0] pend_lo_o,
  output logic             req_hi_o,
  output logic             req_lo_o,
  output logic             wake_o
);
  logic [N_SRC-1:0] cond, pend;

  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    logic [2:0] code;
    logic       want_rise, want_fall, want_high, want_low;
    assign code      = {code2_i[i], code1_i[i], code0_i[i]};
    assign want_rise = (code == TRIG_RISE) || (code == TRIG_BOTH);
    assign want_fall = (code == TRIG_FALL) || (code == TRIG_BOTH);
    assign want_high = (code == TRIG_HIGH);
    assign want_low  = (code == TRIG_LOW);
    assign rise_set_o[i] = want_rise & rise_i[i];
    assign fall_set_o[i] = want_fall & fall_i[i];
    assign cond[i] = (want_rise & rise_stat_i[i]) | (want_fall & fall_stat_i[i])
                   | (want_high & lvl_i[i]) | (want_low & ~lvl_i[i]);
  end

  assign pend      = cond & ena_i;
  assign pend_hi_o = pend & route_i;
  assign pend_lo_o = pend & ~route_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_hi_o <= 1'b0;
      req_lo_o <= 1'b0;
      wake_o   <= 1'b0;
    end else begin
      req_hi_o <= |pend_hi_o;
      req_lo_o <= |pend_lo_o;
      wake_o   <= |(cond & wake_en_i);
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  rise_set_i,
  input  logic [N_SRC-1:0]  fall_set_i,
  input  logic [N_SRC-1:0]  pend_hi_i,
  input  logic [N_SRC-1:0]  pend_lo_i,
  output logic [N_SRC-1:0]  code0_o,
  output logic [N_SRC-1:0]  code1_o,
  output logic [N_SRC-1:0]  code2_o,
  output logic [N_SRC-1:0]  ena_o,
  output logic [N_SRC-1:0]  route_o,
  output logic [N_SRC-1:0]  wake_en_o,
  output logic [N_SRC-1:0]  rise_stat_o,
  output logic [N_SRC-1:0]  fall_stat_o
);
  localparam int unsigned N_PAIR = 7;
  localparam logic [N_PAIR-1:0][ADDR_W-1:0] SET_OFS = {
    OFS_ENA_SET, OFS_WAKE_SET, OFS_ROUTE_SET, OFS_SPARE_SET,
    OFS_CODE2_SET, OFS_CODE1_SET, OFS_CODE0_SET};
  localparam logic [N_PAIR-1:0] RST_ONES = 7'b0001000;

  logic [N_PAIR-1:0][N_SRC-1:0] pair_q;
  logic [N_SRC-1:0]             wbits;
  logic [DATA_W-1:0]            test_q;

  assign wbits = wdata_i[N_SRC-1:0];

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic set_hit, clr_hit;
    assign set_hit = wr_en_i && (addr_i == SET_OFS[p]);
    assign clr_hit = wr_en_i && (addr_i == SET_OFS[p] + ADDR_W'(4));
    always_ff @(posedge clk) begin
      if (!rst_n)       pair_q[p] <= RST_ONES[p] ? '1 : '0;
      else if (set_hit) pair_q[p] <= pair_q[p] | wbits;
      else if (clr_hit) pair_q[p] <= pair_q[p] & ~wbits;
    end
  end

  assign code0_o   = pair_q[0];
  assign code1_o   = pair_q[1];
  assign code2_o   = pair_q[2];
  assign route_o   = pair_q[4];
  assign wake_en_o = pair_q[5];
  assign ena_o     = pair_q[6];

  logic [N_SRC-1:0] rise_ack, fall_ack;
  assign rise_ack = (wr_en_i && addr_i == OFS_RISE_STAT) ? wbits : '0;
  assign fall_ack = (wr_en_i && addr_i == OFS_FALL_STAT) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_stat_o <= '0;
      fall_stat_o <= '0;
      test_q      <= '0;
    end else begin
      rise_stat_o <= (rise_stat_o & ~rise_ack) | rise_set_i;
      fall_stat_o <= (fall_stat_o & ~fall_ack) | fall_set_i;
      if (wr_en_i && addr_i == OFS_TEST) test_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CODE0_SET: rdata_o = DATA_W'(pair_q[0]);
      OFS_CODE1_SET: rdata_o = DATA_W'(pair_q[1]);
      OFS_CODE2_SET: rdata_o = DATA_W'(pair_q[2]);
      OFS_CODE2_CLR: rdata_o = DATA_W'(pend_hi_i);
      OFS_SPARE_SET: rdata_o = DATA_W'(pair_q[3]);
      OFS_SPARE_CLR: rdata_o = DATA_W'(pend_lo_i);
      OFS_ROUTE_SET: rdata_o = DATA_W'(pair_q[4]);
      OFS_WAKE_SET:  rdata_o = DATA_W'(pair_q[5]);
      OFS_ENA_SET:   rdata_o = DATA_W'(pair_q[6]);
      OFS_RISE_STAT: rdata_o = DATA_W'(rise_stat_o);
      OFS_FALL_STAT: rdata_o = DATA_W'(fall_stat_o);
      OFS_TEST:      rdata_o = test_q;
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_ctl.sv
module irq_router_ctl
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  irq_raw,
  output logic              req_hi_o,
  output logic              req_lo_o,
  output logic              wake_o
);
  logic [N_SRC-1:0] lvl, rise, fall, rise_set, fall_set;
  logic [N_SRC-1:0] code0, code1, code2, ena_q, route_q, wake_en_q;
  logic [N_SRC-1:0] rise_stat, fall_stat, pend_hi, pend_lo;

  irq_src_front #(.N_SRC(N_SRC), .SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall));

  irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_en), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .rise_set_i(rise_set), .fall_set_i(fall_set),
    .pend_hi_i(pend_hi), .pend_lo_i(pend_lo),
    .code0_o(code0), .code1_o(code1), .code2_o(code2), .ena_o(ena_q),
    .route_o(route_q), .wake_en_o(wake_en_q),
    .rise_stat_o(rise_stat), .fall_stat_o(fall_stat));

  irq_eval #(.N_SRC(N_SRC)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .code0_i(code0), .code1_i(code1), .code2_i(code2), .ena_i(ena_q),
    .route_i(route_q), .wake_en_i(wake_en_q),
    .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .rise_stat_i(rise_stat), .fall_stat_i(fall_stat),
    .rise_set_o(rise_set), .fall_set_o(fall_set),
    .pend_hi_o(pend_hi), .pend_lo_o(pend_lo),
    .req_hi_o(req_hi_o), .req_lo_o(req_lo_o), .wake_o(wake_o));
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_SRC-1:0]  ena_q,
  input logic [N_SRC-1:0]  route_q,
  input logic [N_SRC-1:0]  wake_en_q,
  input logic [N_SRC-1:0]  rise_stat,
  input logic              req_hi_o,
  input logic              req_lo_o,
  input logic              wake_o
);
  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_ENA_SET) |=>
      ((ena_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]))); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_addr == OFS_RISE_STAT) |=> (($past(rise_stat) & ~rise_stat) == '0)); // R4
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |=> (!req_hi_o && !req_lo_o)); // R6
  AST_ROUTE_ALL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '1) |=> !req_lo_o); // R7
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en_q == '0) |=> !wake_o); // R9
endmodule

bind irq_router_ctl irq_router_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ena_q(ena_q), .route_q(route_q),
  .wake_en_q(wake_en_q), .rise_stat(rise_stat),
  .req_hi_o(req_hi_o), .req_lo_o(req_lo_o), .wake_o(wake_o));

// File: tb/irq_router_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_router_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] raw = '0;
  logic        req_hi, req_lo, wake;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  irq_router_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_raw(raw),
    .req_hi_o(req_hi), .req_lo_o(req_lo), .wake_o(wake));

  // {code[2:0], level before, level after, expected pending}
  localparam logic [5:0] VEC [12] = '{
    {3'b001, 1'b0, 1'b1, 1'b1}, {3'b001, 1'b1, 1'b0, 1'b0},
    {3'b010, 1'b1, 1'b0, 1'b1}, {3'b010, 1'b0, 1'b1, 1'b0},
    {3'b011, 1'b0, 1'b1, 1'b1}, {3'b011, 1'b1, 1'b0, 1'b1},
    {3'b101, 1'b0, 1'b1, 1'b1}, {3'b101, 1'b1, 1'b0, 1'b0},
    {3'b110, 1'b1, 1'b0, 1'b1}, {3'b110, 1'b0, 1'b1, 1'b0},
    {3'b000, 1'b0, 1'b1, 1'b0}, {3'b100, 1'b0, 1'b1, 1'b0}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_code(input logic [31:0] b, input logic [2:0] c);
    wr(8'h44, b); wr(8'h4C, b); wr(8'h54, b);
    if (c[0]) wr(8'h40, b);
    if (c[1]) wr(8'h48, b);
    if (c[2]) wr(8'h50, b);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] b;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R2 reset state
    rd(8'h58, v); check("R2 spare reset", v, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R2 code0 reset", v, 32'h0);
    rd(8'h70, v); check("R2 mask reset", v, 32'h0);
    rd(8'h78, v); check("R2 rise stat reset", v, 32'h0);
    check("R2 outputs reset", {29'h0, req_hi, req_lo, wake}, 32'h0);

    // R1 set/clear pairs
    wr(8'h70, 32'h0000_00F0); wr(8'h74, 32'h0000_0030);
    rd(8'h70, v); check("R1 mask set/clear", v, 32'h0000_00C0);
    wr(8'h60, 32'hA500_0000); wr(8'h60, 32'h0000_0000);
    rd(8'h60, v); check("R1 zero bits keep", v, 32'hA500_0000);
    wr(8'h5C, 32'h0000_FFFF);
    rd(8'h58, v); check("R1 spare clear", v, 32'hFFFF_0000);
    wr(8'h74, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);

    // R11 test register, R10 unmapped / clear-only reads
    wr(8'h80, 32'h1234_5678);
    rd(8'h80, v); check("R11 test reg", v, 32'h1234_5678);
    wr(8'h40, 32'h0000_0001);
    rd(8'h44, v); check("R10 clear addr reads 0", v, 32'h0);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, v); check("R10 unmapped read", v, 32'h0);
    rd(8'h70, v); check("R10 unmapped write ignored", v, 32'h0);
    wr(8'h44, 32'h0000_0001);

    // R3 table walk on line 5, urgent route
    b = 32'h1 << 5;
    wr(8'h70, b); wr(8'h60, b);
    for (int e = 0; e < 12; e++) begin
      set_code(b, VEC[e][5:3]);
      raw[5] = VEC[e][2];
      settle(6);
      wr(8'h78, b); wr(8'h7C, b);
      raw[5] = VEC[e][1];
      settle(6);
      rd(8'h54, v);
      check($sformatf("R3 vec %0d pending", e), {31'h0, v[5]}, {31'h0, VEC[e][0]});
      check($sformatf("R3 vec %0d req_hi", e), {31'h0, req_hi}, {31'h0, VEC[e][0]});
    end
    wr(8'h74, b); raw[5] = 1'b0;

    // R8 / R12 latency on line 3, high level
    b = 32'h1 << 3;
    set_code(b, 3'b101); wr(8'h70, b); wr(8'h60, b);
    settle(2);
    raw[3] = 1'b1;
    @(negedge clk);
    rd(8'h54, v); check("R12 not yet after one edge", {31'h0, v[3]}, 32'h0);
    @(negedge clk);
    rd(8'h54, v); check("R12 pending after two edges", {31'h0, v[3]}, 32'h1);
    check("R8 request still low", {31'h0, req_hi}, 32'h0);
    @(negedge clk);
    check("R8 request one clock later", {31'h0, req_hi}, 32'h1);
    wr(8'h74, b); settle(2);
    check("R6 masked drops request", {31'h0, req_hi}, 32'h0);
    rd(8'h54, v); check("R6 masked not in readout", v, 32'h0);
    raw[3] = 1'b0;

    // R4 sticky / W1C and R5 race on line 9, rising
    b = 32'h1 << 9;
    set_code(b, 3'b001);
    raw[9] = 1'b1; settle(6);
    rd(8'h78, v); check("R4 rise captured", {31'h0, v[9]}, 32'h1);
    raw[9] = 1'b0; settle(6);
    rd(8'h78, v); check("R4 sticky after drop", {31'h0, v[9]}, 32'h1);
    rd(8'h7C, v); check("R4 fall not captured", {31'h0, v[9]}, 32'h0);
    wr(8'h78, 32'h0);
    rd(8'h78, v); check("R4 zero write keeps", {31'h0, v[9]}, 32'h1);
    wr(8'h78, b);
    rd(8'h78, v); check("R4 one write clears", {31'h0, v[9]}, 32'h0);
    raw[9] = 1'b1;
    @(negedge clk);
    wr(8'h78, b);
    rd(8'h78, v); check("R5 edge beats clear", {31'h0, v[9]}, 32'h1);
    raw[9] = 1'b0;

    // R7 routing to the ordinary line, line 20
    b = 32'h1 << 20;
    set_code(b, 3'b101); wr(8'h70, b); wr(8'h64, b);
    raw[20] = 1'b1; settle(5);
    rd(8'h5C, v); check("R7 ordinary readout", v, b);
    rd(8'h54, v); check("R7 urgent readout empty", v, 32'h0);
    check("R7 req_lo high", {30'h0, req_hi, req_lo}, 32'h1);
    wr(8'h74, b); raw[20] = 1'b0;

    // R9 wake ignores mask, line 12
    b = 32'h1 << 12;
    set_code(b, 3'b110); wr(8'h68, b);
    settle(5);
    check("R9 wake without mask", {29'h0, req_hi, req_lo, wake}, 32'h1);
    wr(8'h6C, b); settle(2);
    check("R9 wake disabled", {31'h0, wake}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule